// File: doc/BRIEF.md
# DMA Channel Trigger Conditioner

This block sits in front of one DMA channel and decides when that channel may move data. It selects one of several hardware trigger sources, brings it into the local clock domain, and applies a configured polarity and either edge or level detection. It also takes software set and clear requests. The result is a sticky trigger flag. While the flag is set, the block issues transfer grants to the transfer engine. A peripheral request line can gate those grants. A trigger releases either one transfer or a burst of 2^n transfers.

When a burst or single unit completes, the block pulses a done indication. In burst mode it can also tell the address generator to return the source or destination address to the burst start. The channel priority passes through unchanged to an arbiter outside the block. Status exposes the trigger flag and a valid-pending flag. All behaviour is chosen by one configuration word.

Top module: `dtrig_front`

## Requirements
- R1: After reset, `stat_o` is 0 and `grant_o`, `burst_done_o`, `src_wrap_o` and `dst_wrap_o` are low.
- R2: A `sw_set_i` pulse sets the trigger flag (`stat_o[2]`) at the next clock edge. In single mode (config bit 6 = 0) exactly one grant follows, with `burst_done_o` high in that same cycle, and the flag then drops.
- R3: `sw_clr_i` clears the trigger flag at the next edge and restarts the burst count. It wins over a software or hardware set in the same cycle.
- R4: In burst mode (config bit 6 = 1), one trigger yields 2^n grants, where n is config bits 11:8. `burst_done_o` is high together with the last grant.
- R5: A burst exponent above 10 is treated as 10, giving 1024 grants.
- R6: When config bit 0 is 1, grants occur only in cycles where `periph_req_i` is high. The flag holds meanwhile. When bit 0 is 0, a grant occurs every cycle the flag is set.
- R7: Hardware triggering needs config bit 1 = 1. The source is `trig_src_i[trig_sel_i]` for select values 0 to 11. A select of 12 or more picks no source. With bit 1 = 0, hardware inputs never set the flag.
- R8: In edge mode (config bit 5 = 0), the input passes two synchronizer flops. A rising transition (bit 4 = 1) or a falling transition (bit 4 = 0) then sets the flag. The opposite transition does not.
- R9: In level mode (config bit 5 = 1), the flag is set in every cycle where the synchronized input is at its active level (high if bit 4 = 1, low if 0). It therefore reasserts one cycle after a clear while the level is held.
- R10: `src_wrap_o` (config bit 14) and `dst_wrap_o` (config bit 15) pulse together with `burst_done_o`, and only in burst mode.
- R11: `prio_o` equals config bits 17:16.
- R12: `valid_set_i` sets `stat_o[0]` at the next edge. It is cleared by the next `burst_done_o`. `stat_o[1]` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_i | input | 18 | Channel configuration word |
| trig_sel_i | input | 4 | Hardware trigger source select |
| trig_src_i | input | 12 | Hardware trigger sources |
| periph_req_i | input | 1 | Peripheral request line |
| sw_set_i | input | 1 | Software trigger request |
| sw_clr_i | input | 1 | Clear trigger request |
| valid_set_i | input | 1 | Set the valid-pending flag |
| grant_o | output | 1 | One transfer granted this cycle |
| burst_done_o | output | 1 | Last transfer of the unit |
| src_wrap_o | output | 1 | Source address returns to burst start |
| dst_wrap_o | output | 1 | Destination address returns to burst start |
| prio_o | output | 2 | Channel priority (0 highest) |
| stat_o | output | 3 | Bit 2 trigger flag, bit 0 valid pending |

## Verification
Software triggers run in single mode and in bursts of 4, 8 and the clamped 1024. The per-unit grant counts show whether the exponent and its clamp are decoded correctly. Peripheral-gated bursts with a toggling request line show whether gating stalls the count without losing the flag. An abort mid-burst shows whether the clear restarts the count. Hardware inputs are driven as rising and falling edges, a held level, a toggle on an unselected source, and an out-of-range select. Together these tell edge detection, polarity, level re-triggering and source selection apart.

// File: rtl/dtrig_pkg.sv
package dtrig_pkg;

  localparam int DT_CFG_W   = 18;
  localparam int DT_NSRC    = 12;
  localparam int DT_SEL_W   = 4;
  localparam int DT_MAX_POW = 10;
  localparam int DT_SYNC    = 2;

  typedef struct packed {
    logic       preq_en;
    logic       hw_en;
    logic       pol_hi;
    logic       lvl_mode;
    logic       burst;
    logic [3:0] pow;
    logic       src_wrap;
    logic       dst_wrap;
    logic [1:0] prio;
  } dt_cfg_t;

  function automatic dt_cfg_t dt_decode(input logic [DT_CFG_W-1:0] w);
    dt_cfg_t c;
    c.preq_en  = w[0];
    c.hw_en    = w[1];
    c.pol_hi   = w[4];
    c.lvl_mode = w[5];
    c.burst    = w[6];
    c.pow      = w[11:8];
    c.src_wrap = w[14];
    c.dst_wrap = w[15];
    c.prio     = w[17:16];
    return c;
  endfunction

endpackage

// File: rtl/dtrig_rst_sync.sv
module dtrig_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stg_q;
  logic [1:0] stg_d;

  always_comb stg_d = {stg_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= 2'b00;
    else        stg_q <= stg_d;
  end

  assign rst_sync_n = stg_q[1];
endmodule

// File: rtl/dtrig_sync_det.sv
module dtrig_sync_det #(
  parameter int NSRC   = 12,
  parameter int SEL_W  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             pol_hi_i,
  output logic             edge_o,
  output logic             level_o
);
  logic              sel_bit;
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;
  logic              prev_q;
  logic              prev_d;
  logic              s_now;

  // Source mux: selects beyond NSRC pick nothing
  always_comb begin
    sel_bit = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (sel_i == SEL_W'(i)) sel_bit = src_i[i];
    end
  end

  generate
    if (STAGES > 1) begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], sel_bit};
    end else begin : g_single
      always_comb chain_d = sel_bit;
    end
  endgenerate

  assign s_now  = chain_q[STAGES-1];
  assign prev_d = s_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  // Polarity applied to the transition, not to the stored sample, so a
  // polarity change alone never looks like an edge.
  always_comb begin
    if (pol_hi_i) begin
      edge_o  = s_now & ~prev_q;
      level_o = s_now;
    end else begin
      edge_o  = ~s_now & prev_q;
      level_o = ~s_now;
    end
  end
endmodule

// File: rtl/dtrig_flag.sv
module dtrig_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_set_i,
  input  logic sw_clr_i,
  input  logic hw_en_i,
  input  logic lvl_mode_i,
  input  logic hw_edge_i,
  input  logic hw_level_i,
  input  logic unit_done_i,
  output logic flag_o
);
  logic flag_q;
  logic flag_d;
  logic hw_hit;

  assign hw_hit = hw_en_i & (lvl_mode_i ? hw_level_i : hw_edge_i);

  always_comb begin
    flag_d = flag_q;
    if (sw_clr_i)                flag_d = 1'b0;
    else if (sw_set_i || hw_hit) flag_d = 1'b1;
    else if (unit_done_i)        flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/dtrig_burst.sv
module dtrig_burst #(
  parameter int MAX_POW = 10,
  parameter int CNT_W   = MAX_POW
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       grant_i,
  input  logic       clr_i,
  input  logic       burst_i,
  input  logic [3:0] pow_i,
  output logic       done_o
);
  localparam logic [3:0] POW_CAP = 4'(MAX_POW);

  logic [3:0]       eff_pow;
  logic [CNT_W-1:0] last_idx;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  assign eff_pow  = (pow_i > POW_CAP) ? POW_CAP : pow_i;
  assign last_idx = burst_i ? CNT_W'((32'd1 << eff_pow) - 32'd1) : '0;
  assign done_o   = grant_i & (cnt_q == last_idx);
  assign cnt_en   = clr_i | grant_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (done_o) cnt_d = '0;
    else if (grant_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dtrig_front.sv
module dtrig_front
  import dtrig_pkg::*;
#(
  parameter int CFG_W   = DT_CFG_W,
  parameter int NSRC    = DT_NSRC,
  parameter int SEL_W   = DT_SEL_W,
  parameter int MAX_POW = DT_MAX_POW,
  parameter int STAGES  = DT_SYNC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic [SEL_W-1:0] trig_sel_i,
  input  logic [NSRC-1:0]  trig_src_i,
  input  logic             periph_req_i,
  input  logic             sw_set_i,
  input  logic             sw_clr_i,
  input  logic             valid_set_i,
  output logic             grant_o,
  output logic             burst_done_o,
  output logic             src_wrap_o,
  output logic             dst_wrap_o,
  output logic [1:0]       prio_o,
  output logic [2:0]       stat_o
);
  dt_cfg_t cfg;
  logic    rst_q_n;
  logic    hw_edge, hw_level;
  logic    flag;
  logic    unit_done;
  logic    vpend_q, vpend_d;

  assign cfg = dt_decode(cfg_i);

  dtrig_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  dtrig_sync_det #(.NSRC(NSRC), .SEL_W(SEL_W), .STAGES(STAGES)) u_det (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .src_i    (trig_src_i),
    .sel_i    (trig_sel_i),
    .pol_hi_i (cfg.pol_hi),
    .edge_o   (hw_edge),
    .level_o  (hw_level)
  );

  dtrig_flag u_flag (
    .clk         (clk),
    .rst_n       (rst_q_n),
    .sw_set_i    (sw_set_i),
    .sw_clr_i    (sw_clr_i),
    .hw_en_i     (cfg.hw_en),
    .lvl_mode_i  (cfg.lvl_mode),
    .hw_edge_i   (hw_edge),
    .hw_level_i  (hw_level),
    .unit_done_i (unit_done),
    .flag_o      (flag)
  );

  assign grant_o = flag & (~cfg.preq_en | periph_req_i);

  dtrig_burst #(.MAX_POW(MAX_POW)) u_burst (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .grant_i (grant_o),
    .clr_i   (sw_clr_i),
    .burst_i (cfg.burst),
    .pow_i   (cfg.pow),
    .done_o  (unit_done)
  );

  always_comb begin
    vpend_d = vpend_q;
    if (valid_set_i)    vpend_d = 1'b1;
    else if (unit_done) vpend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) vpend_q <= 1'b0;
    else          vpend_q <= vpend_d;
  end

  assign burst_done_o = unit_done;
  assign src_wrap_o   = unit_done & cfg.burst & cfg.src_wrap;
  assign dst_wrap_o   = unit_done & cfg.burst & cfg.dst_wrap;
  assign prio_o       = cfg.prio;
  assign stat_o       = {flag, 1'b0, vpend_q};
endmodule

// File: rtl/dtrig_front_chk.sv
module dtrig_front_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [17:0] cfg_i,
  input logic        periph_req_i,
  input logic        sw_clr_i,
  input logic        valid_set_i,
  input logic        grant_o,
  input logic        burst_done_o,
  input logic        src_wrap_o,
  input logic        dst_wrap_o,
  input logic [2:0]  stat_o
);
  // R2
  grant_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |-> stat_o[2]);

  // R4
  done_with_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done_o |-> grant_o);

  // R3
  clear_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr_i |=> !stat_o[2]);

  // R6
  periph_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i[0] && !periph_req_i) |-> !grant_o);

  // R10
  wrap_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_wrap_o || dst_wrap_o) |-> (burst_done_o && cfg_i[6]));

  // R12
  valid_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    valid_set_i |=> stat_o[0]);
endmodule

bind dtrig_front dtrig_front_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_q_n),
  .cfg_i        (cfg_i),
  .periph_req_i (periph_req_i),
  .sw_clr_i     (sw_clr_i),
  .valid_set_i  (valid_set_i),
  .grant_o      (grant_o),
  .burst_done_o (burst_done_o),
  .src_wrap_o   (src_wrap_o),
  .dst_wrap_o   (dst_wrap_o),
  .stat_o       (stat_o)
);

// File: tb/dtrig_front_bench.sv
module dtrig_front_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [17:0] cfg_i;
  logic [3:0]  trig_sel_i;
  logic [11:0] trig_src_i;
  logic        periph_req_i, sw_set_i, sw_clr_i, valid_set_i;
  logic        grant_o, burst_done_o, src_wrap_o, dst_wrap_o;
  logic [1:0]  prio_o;
  logic [2:0]  stat_o;

  typedef struct {
    int grants;
    bit sw;
    bit dw;
  } unit_t;

  unit_t sb[$];
  int    checks = 0;
  int    errors = 0;
  int    gcnt   = 0;
  bit    done_run = 0;

  always #4 clk = ~clk;

  dtrig_front u_dtrig_front (
    .clk(clk), .rst_n(rst_n), .cfg_i(cfg_i), .trig_sel_i(trig_sel_i),
    .trig_src_i(trig_src_i), .periph_req_i(periph_req_i), .sw_set_i(sw_set_i),
    .sw_clr_i(sw_clr_i), .valid_set_i(valid_set_i), .grant_o(grant_o),
    .burst_done_o(burst_done_o), .src_wrap_o(src_wrap_o), .dst_wrap_o(dst_wrap_o),
    .prio_o(prio_o), .stat_o(stat_o)
  );

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_set();
    sw_set_i = 1'b1; cyc(1); sw_set_i = 1'b0;
  endtask

  task automatic pulse_clr();
    sw_clr_i = 1'b1; cyc(1); sw_clr_i = 1'b0;
  endtask

  task automatic expect_unit(int g, bit s, bit d);
    unit_t u;
    u.grants = g; u.sw = s; u.dw = d;
    sb.push_back(u);
  endtask

  task automatic finish_run();
    if (!done_run) begin
      done_run = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Monitor: samples 1 ns before each rising edge
  initial begin
    forever begin
      @(negedge clk);
      #3;
      if (rst_n) begin
        if (sw_clr_i) gcnt = 0;
        if (grant_o) gcnt++;
        if (burst_done_o) begin
          if (sb.size() == 0) begin
            checks++; errors++;
            $display("FAIL R4 unexpected unit end actual=%0d expected=0", gcnt);
          end else begin
            unit_t u;
            u = sb.pop_front();
            check_eq("R4", "grants in unit", gcnt, u.grants);
            check_eq("R10", "src wrap", int'(src_wrap_o), int'(u.sw));
            check_eq("R10", "dst wrap", int'(dst_wrap_o), int'(u.dw));
          end
          gcnt = 0;
        end
      end
    end
  end

  initial begin
    cyc(150000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; cfg_i = '0; trig_sel_i = '0; trig_src_i = '0;
    periph_req_i = 1'b0; sw_set_i = 1'b0; sw_clr_i = 1'b0; valid_set_i = 1'b0;
    cyc(3);
    // R1 reset state
    check_eq("R1", "stat", int'(stat_o), 0);
    check_eq("R1", "grant", int'(grant_o), 0);
    check_eq("R1", "done", int'(burst_done_o), 0);
    rst_n = 1'b1;
    cyc(5);

    // R11 priority pass-through
    cfg_i = 18'h2_0000;
    cyc(1);
    check_eq("R11", "prio", int'(prio_o), 2);

    // R2 single-mode software trigger; wrap bits set but ignored (R10)
    cfg_i = 18'h0C000;
    expect_unit(1, 0, 0);
    pulse_set();
    check_eq("R2", "flag after set", int'(stat_o[2]), 1);
    cyc(4);
    check_eq("R2", "flag after unit", int'(stat_o[2]), 0);

    // R4 burst of 4 with source wrap
    cfg_i = 18'h04240;
    expect_unit(4, 1, 0);
    pulse_set();
    cyc(8);
    check_eq("R4", "flag after burst", int'(stat_o[2]), 0);

    // R6 burst of 8, dst wrap, gated by toggling peripheral request
    cfg_i = 18'h08341;
    expect_unit(8, 0, 1);
    pulse_set();
    cyc(2);
    check_eq("R6", "no grant while request low", int'(grant_o), 0);
    check_eq("R6", "flag held while request low", int'(stat_o[2]), 1);
    for (int i = 0; i < 20; i++) begin
      periph_req_i = ~periph_req_i;
      cyc(1);
    end
    periph_req_i = 1'b0;
    cyc(2);
    check_eq("R6", "flag after gated burst", int'(stat_o[2]), 0);

    // R3 abort mid-burst restarts the count
    cfg_i = 18'h00241;
    pulse_set();
    cyc(2);
    periph_req_i = 1'b1; cyc(2); periph_req_i = 1'b0;
    pulse_clr();
    check_eq("R3", "flag after abort", int'(stat_o[2]), 0);
    expect_unit(4, 0, 0);
    pulse_set();
    periph_req_i = 1'b1; cyc(10); periph_req_i = 1'b0;
    check_eq("R3", "flag after full burst", int'(stat_o[2]), 0);
    // R3 clear wins over set in the same cycle
    sw_set_i = 1'b1; sw_clr_i = 1'b1; cyc(1); sw_set_i = 1'b0; sw_clr_i = 1'b0;
    cyc(2);
    check_eq("R3", "clear beats set", int'(stat_o[2]), 0);

    // R12 valid pending
    cfg_i = 18'h00000;
    valid_set_i = 1'b1; cyc(1); valid_set_i = 1'b0;
    check_eq("R12", "valid pending set", int'(stat_o[0]), 1);
    check_eq("R12", "stat bit1", int'(stat_o[1]), 0);
    expect_unit(1, 0, 0);
    pulse_set();
    cyc(4);
    check_eq("R12", "valid pending cleared", int'(stat_o[0]), 0);

    // R8 rising edge on source 5
    cfg_i = 18'h00012; trig_sel_i = 4'd5;
    cyc(3);
    expect_unit(1, 0, 0);
    trig_src_i[5] = 1'b1; cyc(2); trig_src_i[5] = 1'b0;
    cyc(6);
    check_eq("R8", "flag after rising unit", int'(stat_o[2]), 0);
    // R7 unselected source toggles
    trig_src_i[3] = 1'b1; cyc(4);
    check_eq("R7", "unselected source", int'(stat_o[2]), 0);
    trig_src_i[3] = 1'b0; cyc(4);
    // R7 out-of-range select
    trig_sel_i = 4'd13;
    trig_src_i = 12'hFFF; cyc(4);
    check_eq("R7", "select out of range", int'(stat_o[2]), 0);
    trig_src_i = 12'h000; cyc(4);
    // R7 hardware disabled
    cfg_i = 18'h00010; trig_sel_i = 4'd5;
    trig_src_i[5] = 1'b1; cyc(4);
    check_eq("R7", "hw disabled", int'(stat_o[2]), 0);
    trig_src_i[5] = 1'b0; cyc(4);

    // R8 falling edge polarity on source 7
    cfg_i = 18'h00002; trig_sel_i = 4'd7;
    cyc(3);
    trig_src_i[7] = 1'b1; cyc(5);
    check_eq("R8", "rising ignored when falling-active", int'(stat_o[2]), 0);
    expect_unit(1, 0, 0);
    trig_src_i[7] = 1'b0;
    cyc(8);
    check_eq("R8", "flag after falling unit", int'(stat_o[2]), 0);

    // R8 edge mode: held input does not retrigger after clear
    cfg_i = 18'h00013; trig_sel_i = 4'd2;
    cyc(2);
    trig_src_i[2] = 1'b1; cyc(4);
    check_eq("R8", "edge sets flag", int'(stat_o[2]), 1);
    pulse_clr();
    cyc(3);
    check_eq("R8", "edge no retrigger", int'(stat_o[2]), 0);
    trig_src_i[2] = 1'b0; cyc(4);

    // R9 level mode: held level reasserts flag after clear
    cfg_i = 18'h00033;
    trig_src_i[2] = 1'b1; cyc(4);
    check_eq("R9", "level sets flag", int'(stat_o[2]), 1);
    pulse_clr();
    check_eq("R9", "clear takes effect", int'(stat_o[2]), 0);
    cyc(2);
    check_eq("R9", "level reasserts", int'(stat_o[2]), 1);
    trig_src_i[2] = 1'b0; cyc(4);
    pulse_clr();
    cyc(3);
    check_eq("R9", "level released", int'(stat_o[2]), 0);

    // R5 exponent clamp: 15 behaves as 10
    cfg_i = 18'h00F40;
    expect_unit(1024, 0, 0);
    pulse_set();
    cyc(1040);
    check_eq("R5", "flag after clamped burst", int'(stat_o[2]), 0);

    cyc(4);
    check_eq("R4", "pending units", sb.size(), 0);
    finish_run();
  end
endmodule